// File: doc/BRIEF.md
# Asynchronous Serial Receiver and Transmitter with Error Flags

This block receives and sends asynchronous serial characters and holds them in byte-wide registers on a small processor bus. The serial input is sampled on a 16x oversampling enable (`tick`). A baud generator outside the block drives that enable. A character has a start bit, 8 or 9 data bits sent least significant first, an optional parity bit and one stop bit. Two pins set parity: one enables it, the other picks odd or even.

Both directions are double buffered. A finished received character moves from the shift register into a receive buffer, and the next character can shift in behind it. A byte written for transmission waits in a transmit buffer while the previous frame is still leaving. A framing-error flag and a parity-error flag are loaded together with each received character, so they always describe the character that can be read.

The flags clear only through a two-step sequence: a status read, then a read of the low data register. Any other access between the two steps cancels the sequence. The bus uses plain read and write strobes with a combinational read mux. It has no back-pressure: a new received character replaces an unread one, and a write to the transmit buffer while it is full replaces the waiting byte.

Top module: `uart_status_regs`

## Requirements
- R1: A valid frame places its data in the low data register (address 3) and sets the receive-full bit (status bit 5); a read of address 3 clears receive-full.
- R2: When `cfg_nine`=1, the received ninth bit reads at bit 7 of the high data register (address 2), and the ninth bit to send is written to and read back from bit 6; bits 5..0 of address 2 read zero. When `cfg_nine`=0, bit 7 reads zero.
- R3: A zero sampled at the stop-bit position sets the framing-error flag (status bit 1).
- R4: When `cfg_par_en`=1, a parity bit that does not give even parity (`cfg_par_odd`=0) or odd parity (`cfg_par_odd`=1) over the data bits and itself sets the parity-error flag (status bit 0).
- R5: The error flags clear only when a status read (address 0) that sees them set is followed by a read of address 3. A read of address 3 without that status read leaves them set.
- R6: If any access other than a read of address 2 comes between the status read and the read of address 3, the clear is abandoned and the flags stay set.
- R7: The flags are replaced together with the data whenever a character enters the receive buffer, so a good character that follows an errored one reads with both flags at zero.
- R8: Bit 0 of the second status register (address 1) reads 1 while a character is being received and 0 otherwise. Bits 7..1 of address 1 always read zero.
- R9: A start bit is accepted only if a majority of three samples near mid-bit are low. A shorter low pulse is ignored and produces no character.
- R10: A transmitted frame is sent on `txd` as a low start bit, the data bits least significant first (plus the ninth bit when `cfg_nine`=1), the parity bit when enabled, and a high stop bit, each lasting 16 ticks. `txd` idles high.
- R11: Status bit 7 reads 1 while the transmit buffer is empty. A second byte can be written while the first frame is being sent, and the two frames leave back to back.
- R12: A received character stays readable at address 3 while the next character is being shifted in.
- R13: After reset, status reads 8'h80, the second status register and both data registers read 8'h00, and `txd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 16x oversampling enable |
| rxd | input | 1 | Serial input (asynchronous) |
| txd | output | 1 | Serial output |
| cfg_nine | input | 1 | 1 = nine data bits, 0 = eight |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| bus_addr | input | 2 | Register select: 0 status, 1 second status, 2 data high, 3 data low |
| bus_rd | input | 1 | Read strobe (side effects on this clock edge) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |

## Verification
A wrong bit counter or a bad vote window corrupts the data byte or raises a false flag. This shows up on the first status and data read after the frame's stop bit, one character time after the start edge. A clear-arming register that latches wrongly shows up as a flag that survives, or vanishes after, the very next read of address 3. The abandon and no-arm sequences test both of those cases. Transmit errors are caught bit by bit at mid-bit on `txd`, so a wrong frame length or bit order fails within one frame.

// File: rtl/uart_sr_pkg.sv
package uart_sr_pkg;
  localparam int DW = 9;
  localparam int FW = 12;

  typedef enum logic [1:0] {
    A_STAT  = 2'd0,
    A_STAT2 = 2'd1,
    A_DHI   = 2'd2,
    A_DLO   = 2'd3
  } reg_addr_e;

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/uart_sr_rx.sv
module uart_sr_rx
  import uart_sr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          cfg_nine,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          fe,
  output logic          pe,
  output logic          active
);
  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] P_S0  = PW'(OSR / 2 - 1);
  localparam logic [PW-1:0] P_S1  = PW'(OSR / 2);
  localparam logic [PW-1:0] P_DEC = PW'(OSR / 2 + 1);
  localparam logic [PW-1:0] P_END = PW'(OSR - 1);

  logic s1, s2, prev, busy, pbit, v;
  logic [PW-1:0] ph;
  logic [3:0] idx, nd, stop_idx;
  logic [1:0] win;
  logic [DW-1:0] sh, dm;

  assign nd       = cfg_nine ? 4'd9 : 4'd8;
  assign stop_idx = nd + 4'd1 + {3'b0, cfg_par_en};
  assign dm       = cfg_nine ? sh : {1'b0, sh[7:0]};
  assign v        = vote3({win, s2});
  assign active   = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1; busy <= 1'b0; pbit <= 1'b0;
      ph <= '0; idx <= '0; win <= '0; sh <= '0;
      done <= 1'b0; data <= '0; fe <= 1'b0; pe <= 1'b0;
    end else begin
      s1   <= rxd;
      s2   <= s1;
      done <= 1'b0;
      if (tick) begin
        prev <= s2;
        if (!busy) begin
          if (prev && !s2) begin
            busy <= 1'b1;
            ph   <= '0;
            idx  <= '0;
          end
        end else begin
          ph <= ph + 1'b1;
          if (ph == P_S0 || ph == P_S1) win <= {win[0], s2};
          if (ph == P_DEC) begin
            if (idx == 4'd0) begin
              if (v) busy <= 1'b0;
            end else if (idx <= nd) begin
              sh[idx - 4'd1] <= v;
            end else if (idx == stop_idx) begin
              busy <= 1'b0;
              done <= 1'b1;
              data <= dm;
              fe   <= !v;
              pe   <= cfg_par_en && ((^dm ^ pbit) != cfg_par_odd);
            end else begin
              pbit <= v;
            end
          end
          if (ph == P_END) idx <= idx + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_sr_tx.sv
module uart_sr_tx
  import uart_sr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          cfg_nine,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  output logic          txd,
  output logic          buf_empty
);
  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] P_END = PW'(OSR - 1);

  logic full, busy;
  logic [DW-1:0] bufd, dm;
  logic [PW-1:0] ph;
  logic [3:0] idx, last, nd;
  logic [FW-1:0] fr, nf;

  assign nd = cfg_nine ? 4'd9 : 4'd8;
  assign dm = cfg_nine ? bufd : {1'b0, bufd[7:0]};

  always_comb begin
    nf    = '1;
    nf[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < int'(nd)) nf[i + 1] = dm[i];
    end
    if (cfg_par_en) nf[nd + 4'd1] = ^dm ^ cfg_par_odd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0; busy <= 1'b0; bufd <= '0;
      ph <= '0; idx <= '0; last <= '0; fr <= '1;
    end else begin
      if (tick && busy) begin
        ph <= ph + 1'b1;
        if (ph == P_END) begin
          idx <= idx + 4'd1;
          fr  <= {1'b1, fr[FW-1:1]};
          if (idx == last) busy <= 1'b0;
        end
      end else if (tick && full) begin
        fr   <= nf;
        last <= nd + 4'd1 + {3'b0, cfg_par_en};
        busy <= 1'b1;
        ph   <= '0;
        idx  <= '0;
        full <= 1'b0;
      end
      if (wr) begin
        bufd <= wdata;
        full <= 1'b1;
      end
    end
  end

  assign txd       = !busy || fr[0];
  assign buf_empty = !full;
endmodule

// File: rtl/uart_status_regs.sv
module uart_status_regs
  import uart_sr_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       txd,
  input  logic       cfg_nine,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  reg_addr_e a;
  logic rx_done, rx_fe, rx_pe, rx_active;
  logic [DW-1:0] rx_data, rbuf;
  logic rx_full, fe_q, pf_q, arm_fe, arm_pf, t8, tx_empty, tx_wr;

  assign a     = reg_addr_e'(bus_addr);
  assign tx_wr = bus_wr && a == A_DLO;

  uart_sr_rx #(.OSR(OSR)) u_rx (
    .clk, .rst_n, .tick, .rxd, .cfg_nine, .cfg_par_en, .cfg_par_odd,
    .done(rx_done), .data(rx_data), .fe(rx_fe), .pe(rx_pe), .active(rx_active)
  );

  uart_sr_tx #(.OSR(OSR)) u_tx (
    .clk, .rst_n, .tick, .wr(tx_wr), .wdata({t8, bus_wdata}),
    .cfg_nine, .cfg_par_en, .cfg_par_odd, .txd, .buf_empty(tx_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf <= '0; rx_full <= 1'b0; fe_q <= 1'b0; pf_q <= 1'b0;
      arm_fe <= 1'b0; arm_pf <= 1'b0; t8 <= 1'b0;
    end else begin
      if (bus_wr) begin
        arm_fe <= 1'b0;
        arm_pf <= 1'b0;
        if (a == A_DHI) t8 <= bus_wdata[6];
      end else if (bus_rd) begin
        unique case (a)
          A_STAT: begin
            arm_fe <= fe_q;
            arm_pf <= pf_q;
          end
          A_DHI: ;
          A_DLO: begin
            fe_q    <= fe_q & ~arm_fe;
            pf_q    <= pf_q & ~arm_pf;
            arm_fe  <= 1'b0;
            arm_pf  <= 1'b0;
            rx_full <= 1'b0;
          end
          default: begin
            arm_fe <= 1'b0;
            arm_pf <= 1'b0;
          end
        endcase
      end
      if (rx_done) begin
        rbuf    <= rx_data;
        fe_q    <= rx_fe;
        pf_q    <= rx_pe;
        rx_full <= 1'b1;
        arm_fe  <= 1'b0;
        arm_pf  <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (a)
      A_STAT:  bus_rdata = {tx_empty, 1'b0, rx_full, 3'b000, fe_q, pf_q};
      A_STAT2: bus_rdata = {7'b0, rx_active};
      A_DHI:   bus_rdata = {rbuf[8], t8, 6'b0};
      default: bus_rdata = rbuf[7:0];
    endcase
  end
endmodule

// File: rtl/uart_sr_chk.sv
module uart_sr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic       fe_q,
  input logic       pf_q,
  input logic       rx_done,
  input logic       rx_full,
  input logic       tx_empty
);
  AST_ST2_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> (bus_rdata[7:1] == 7'b0)); // R8

  AST_DHI_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd2) |-> (bus_rdata[5:0] == 6'b0)); // R2

  AST_FE_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fe_q) |-> ($past(bus_rd && !bus_wr && bus_addr == 2'd3) || $past(rx_done))); // R5

  AST_PF_CLEAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pf_q) |-> ($past(bus_rd && !bus_wr && bus_addr == 2'd3) || $past(rx_done))); // R5

  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_full); // R1

  AST_TXWR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3) |=> !tx_empty); // R11
endmodule

bind uart_status_regs uart_sr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .fe_q(fe_q), .pf_q(pf_q), .rx_done(rx_done),
  .rx_full(rx_full), .tx_empty(tx_empty)
);

// File: tb/test_uart_status_regs.sv
module test_uart_status_regs;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, rxd = 1'b1, txd;
  logic cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  uart_status_regs i_uart_status_regs (
    .clk, .rst_n, .tick, .rxd, .txd, .cfg_nine, .cfg_par_en, .cfg_par_odd,
    .bus_addr, .bus_rd, .bus_wr, .bus_wdata, .bus_rdata
  );

  // [13] nine [12] par_en [11] odd [10:2] data [1] bad stop [0] flip parity
  localparam logic [13:0] VEC [0:5] = '{
    {1'b0, 1'b0, 1'b0, 9'h055, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 9'h0A3, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 9'h00F, 1'b0, 1'b1},
    {1'b1, 1'b0, 1'b0, 9'h1C4, 1'b1, 1'b0},
    {1'b1, 1'b1, 1'b0, 9'h101, 1'b1, 1'b1},
    {1'b1, 1'b1, 1'b1, 9'h0FE, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] ad, output logic [7:0] v);
    @(negedge clk);
    bus_addr = ad; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] ad, input logic [7:0] d);
    @(negedge clk);
    bus_addr = ad; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic send(input logic nine, input logic pen, input logic odd,
                      input logic [8:0] d, input logic bstop, input logic flip);
    logic [11:0] f;
    int n;
    logic [8:0] dm;
    dm = nine ? d : {1'b0, d[7:0]};
    n = 0;
    f = '1;
    f[n++] = 1'b0;
    for (int i = 0; i < (nine ? 9 : 8); i++) f[n++] = dm[i];
    if (pen) f[n++] = (^dm) ^ odd ^ flip;
    f[n++] = !bstop;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxd = f[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  task automatic capture(input int n, output logic [11:0] f);
    f = '1;
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (7) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      f[i] = txd;
      repeat (16) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [11:0] fa, fb, expf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R13 reset state
    rd(2'd0, v); chk("R13 status", {4'h0, v}, 12'h080);
    rd(2'd1, v); chk("R13 status2", {4'h0, v}, 12'h000);
    rd(2'd2, v); chk("R13 data high", {4'h0, v}, 12'h000);
    rd(2'd3, v); chk("R13 data low", {4'h0, v}, 12'h000);
    chk("R13 txd idle", {11'h0, txd}, 12'h001);

    // table: R1 R2 R3 R4 and R5 clear sequence
    for (int k = 0; k < 6; k++) begin
      logic [13:0] e;
      logic expfe, exppe;
      logic [8:0] d;
      e = VEC[k];
      cfg_nine = e[13]; cfg_par_en = e[12]; cfg_par_odd = e[11];
      d = e[10:2];
      expfe = e[1];
      exppe = e[12] & e[0];
      send(e[13], e[12], e[11], d, e[1], e[0]);
      rd(2'd0, v); chk("R1 R3 R4 status", {4'h0, v}, {4'h0, 1'b1, 1'b0, 1'b1, 3'b0, expfe, exppe});
      rd(2'd2, v); chk("R2 data high", {4'h0, v}, {4'h0, d[8] & e[13], 7'b0});
      rd(2'd3, v); chk("R1 data low", {4'h0, v}, {4'h0, d[7:0]});
      rd(2'd0, v); chk("R5 cleared", {4'h0, v}, 12'h080);
    end

    cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

    // R9 short glitch ignored
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (40) @(negedge clk);
    rd(2'd1, v); chk("R9 no activity", {4'h0, v}, 12'h000);
    rd(2'd0, v); chk("R9 no char", {4'h0, v}, 12'h080);

    // R12 and R8: held data during next reception, active flag
    send(1'b0, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b0);
    fork
      send(1'b0, 1'b0, 1'b0, 9'h0C6, 1'b0, 1'b0);
      begin
        repeat (60) @(negedge clk);
        rd(2'd1, v); chk("R8 active mid frame", {4'h0, v}, 12'h001);
        rd(2'd3, v); chk("R12 held data", {4'h0, v}, 12'h03C);
      end
    join
    rd(2'd1, v); chk("R8 idle after frame", {4'h0, v}, 12'h000);
    rd(2'd3, v); chk("R12 next data", {4'h0, v}, 12'h0C6);

    // R5 read without arming keeps flag
    send(1'b0, 1'b0, 1'b0, 9'h033, 1'b1, 1'b0);
    rd(2'd3, v);
    rd(2'd0, v); chk("R5 unarmed keeps FE", {4'h0, v}, 12'h082);
    rd(2'd3, v);
    rd(2'd0, v); chk("R5 armed clear", {4'h0, v}, 12'h080);

    // R6 abandoned sequence
    send(1'b0, 1'b0, 1'b0, 9'h044, 1'b1, 1'b0);
    rd(2'd0, v);
    rd(2'd1, v);
    rd(2'd3, v);
    rd(2'd0, v); chk("R6 abandoned keeps FE", {4'h0, v}, 12'h082);
    rd(2'd3, v);
    rd(2'd0, v); chk("R6 later clear", {4'h0, v}, 12'h080);

    // R7 flags replaced with next character
    send(1'b0, 1'b0, 1'b0, 9'h011, 1'b1, 1'b0);
    send(1'b0, 1'b0, 1'b0, 9'h022, 1'b0, 1'b0);
    rd(2'd0, v); chk("R7 flags follow char", {4'h0, v}, 12'h0A0);
    rd(2'd3, v); chk("R7 data", {4'h0, v}, 12'h022);

    // R10 nine bits, odd parity transmit
    cfg_nine = 1'b1; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    wr(2'd2, 8'h40);
    rd(2'd2, v); chk("R2 T8 readback", {4'h0, v}, 12'h040);
    expf = {1'b1, (^9'h1A5) ^ 1'b1, 9'h1A5, 1'b0};
    fork
      capture(12, fa);
      wr(2'd3, 8'hA5);
    join
    chk("R10 frame 9 bit odd", fa, expf);
    chk("R10 idle high", {11'h0, txd}, 12'h001);

    // R11 back to back transmit
    cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    repeat (20) @(negedge clk);
    fork
      begin
        capture(10, fa);
        capture(10, fb);
      end
      begin
        wr(2'd3, 8'h5A);
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R11 empty after load", {4'h0, v}, 12'h080);
        wr(2'd3, 8'hC3);
        rd(2'd0, v); chk("R11 full while sending", {4'h0, v}, 12'h000);
      end
    join
    chk("R11 first frame", fa, {2'b11, 1'b1, 8'h5A, 1'b0});
    chk("R11 second frame", fb, {2'b11, 1'b1, 8'hC3, 1'b0});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule